// File: doc/BRIEF.md
# Flash Reset and Ready Sequencer

This block watches the already-synchronised active-low hardware reset pin of a flash array and turns a qualified low pulse into the internal reset actions. A low level that stays for a parameterised number of clock samples makes the block stop the embedded program/erase engine, return the command decoder to array-read mode, and start a recovery window. A shorter low level only blocks host commands while it lasts. Nothing else happens.

Recovery length depends on whether the engine was busy on the cycle the pulse qualified. If it was busy, the internal reset takes a long interval. If it was idle, a short one. Separately, host access may only resume a fixed settling time after the pin returns high. The two intervals run on their own timers, and commands are accepted again when both have expired. An aborted operation is never resumed. The host must issue a new command sequence. The ready/busy pin is open-drain, so the block outputs a pull-low enable. That enable follows the engine's busy flag, and it is released as soon as a reset is qualified.

Top module: `flash_rst_ready_seq`

## Requirements
- R1: After power-on reset, with the pin high, `accept_cmds` is 1, `abort_req` and `read_array_req` are 0, and `ryby_pull_low` is 0 while the engine is idle.
- R2: A low level on `reset_pin_n` lasting fewer than MIN_PULSE clock samples produces no `abort_req` or `read_array_req`. It leaves `ryby_pull_low` unchanged, and `accept_cmds` returns to 1 in the cycle the pin is high again.
- R3: On the MIN_PULSE-th consecutive low sample, `abort_req` and `read_array_req` are both 1 for exactly the following cycle. This happens once per qualified pulse, however long the pin stays low.
- R4: `accept_cmds` is 0 in every cycle in which `reset_pin_n` is 0.
- R5: From the cycle `abort_req` is 1 until recovery ends, `ryby_pull_low` is 0 even if `engine_busy` is still 1.
- R6: If `engine_busy` was 1 on the qualifying sample, `accept_cmds` rises on the later of two clock edges. The first is the edge T_READY edges after the edge that raises `abort_req`. The second is the edge T_RH edges after the first edge that samples the pin high.
- R7: If `engine_busy` was 0 on the qualifying sample, the same rule as R6 applies with T_RP in place of T_READY.
- R8: A short low level during recovery does not abort again. It discards the settling count, which restarts from the next high sample.
- R9: Outside recovery, `ryby_pull_low` equals `engine_busy`. It is never 1 while `engine_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset of the sequencer, active low, asynchronous |
| reset_pin_n | input | 1 | Synchronised hardware reset pin, active low |
| engine_busy | input | 1 | Program/erase engine is running |
| abort_req | output | 1 | One-cycle request to stop the running engine operation |
| read_array_req | output | 1 | One-cycle request to return the command decoder to array-read mode |
| ryby_pull_low | output | 1 | Enable for the open-drain ready/busy pull-down |
| accept_cmds | output | 1 | Host reads and writes may be accepted |

## Verification
The internal-reset interval and the post-release settling interval can expire on the same clock edge. The bench provokes this by holding the pin low for exactly as long as the long busy interval minus the settling time. It then requires `accept_cmds` to be low on the preceding edge and high on that shared edge, with no extra cycle. A second case puts a pin release in the same cycle as the settling restart: a short glitch arrives during recovery, and the bench checks that the rise moves to the settling time after the second release.

// File: rtl/frs_pkg.sv
package frs_pkg;
   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_RECOV = 1'b1
   } frs_state_e;

   function automatic int frs_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/frs_pulse_filter.sv
module frs_pulse_filter #(
   parameter int MIN_PULSE = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_n,
   output logic qualify
);
   generate
      if (MIN_PULSE == 1) begin : g_edge
         logic seen_low;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) seen_low <= 1'b0;
            else        seen_low <= ~pin_n;
         end
         assign qualify = ~pin_n & ~seen_low;
      end else begin : g_count
         localparam int LW = $clog2(MIN_PULSE + 1);
         localparam logic [LW-1:0] LAST = LW'(MIN_PULSE - 1);
         localparam logic [LW-1:0] SAT  = LW'(MIN_PULSE);
         logic [LW-1:0] low_cnt;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)            low_cnt <= '0;
            else if (pin_n)        low_cnt <= '0;
            else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
         end
         assign qualify = ~pin_n & (low_cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/frs_interval_timer.sv
module frs_interval_timer #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          clear,
   output logic          armed,
   output logic          expired
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (load) begin
         cnt   <= load_val;
         armed <= 1'b1;
      end else if (clear) begin
         armed <= 1'b0;
      end else if (armed && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = armed & (cnt == '0);
endmodule

// File: rtl/flash_rst_ready_seq.sv
module flash_rst_ready_seq
   import frs_pkg::*;
#(
   parameter int MIN_PULSE = 4,
   parameter int T_READY   = 20,
   parameter int T_RP      = 8,
   parameter int T_RH      = 5
) (
   input  logic clk,
   input  logic por_n,
   input  logic reset_pin_n,
   input  logic engine_busy,
   output logic abort_req,
   output logic read_array_req,
   output logic ryby_pull_low,
   output logic accept_cmds
);
   localparam int T_MAX = frs_max(frs_max(T_READY, T_RP), T_RH);
   localparam int CW    = $clog2(T_MAX + 1);
   localparam logic [CW-1:0] LD_READY = CW'(T_READY - 1);
   localparam logic [CW-1:0] LD_RP    = CW'(T_RP - 1);
   localparam logic [CW-1:0] LD_RH    = CW'(T_RH - 1);

   initial begin
      if (MIN_PULSE < 1) $error("MIN_PULSE must be at least 1");
      if (T_READY < 1 || T_RP < 1 || T_RH < 1) $error("recovery intervals must be at least 1");
   end

   frs_state_e state;
   logic qualify, abort_q;
   logic int_armed, int_done;
   logic set_armed, set_done;
   logic in_rec, set_load, rec_exit;

   frs_pulse_filter #(.MIN_PULSE(MIN_PULSE)) u_filter (
      .clk     (clk),
      .por_n   (por_n),
      .pin_n   (reset_pin_n),
      .qualify (qualify)
   );

   // internal reset interval: length picked from engine state at qualification
   frs_interval_timer #(.CW(CW)) u_int_tmr (
      .clk      (clk),
      .por_n    (por_n),
      .load     (qualify),
      .load_val (engine_busy ? LD_READY : LD_RP),
      .clear    (1'b0),
      .armed    (int_armed),
      .expired  (int_done)
   );

   // settling interval: starts at first high sample in recovery, lost on any low
   assign in_rec   = (state == ST_RECOV);
   assign set_load = in_rec & reset_pin_n & ~set_armed;

   frs_interval_timer #(.CW(CW)) u_set_tmr (
      .clk      (clk),
      .por_n    (por_n),
      .load     (set_load),
      .load_val (LD_RH),
      .clear    (~reset_pin_n),
      .armed    (set_armed),
      .expired  (set_done)
   );

   assign rec_exit = in_rec & reset_pin_n & set_done & int_done & int_armed;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state   <= ST_IDLE;
         abort_q <= 1'b0;
      end else begin
         abort_q <= qualify;
         if (qualify)       state <= ST_RECOV;
         else if (rec_exit) state <= ST_IDLE;
      end
   end

   assign abort_req      = abort_q;
   assign read_array_req = abort_q;
   assign ryby_pull_low  = engine_busy & ~in_rec;
   assign accept_cmds    = reset_pin_n & ~in_rec;
endmodule

// File: rtl/flash_rst_ready_seq_chk.sv
module flash_rst_ready_seq_chk #(
   parameter int MIN_PULSE = 4
) (
   input logic clk,
   input logic por_n,
   input logic reset_pin_n,
   input logic engine_busy,
   input logic abort_req,
   input logic read_array_req,
   input logic ryby_pull_low,
   input logic accept_cmds
);
   localparam int KW = $clog2(MIN_PULSE + 1);
   logic [KW-1:0] seen_low;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                        seen_low <= '0;
      else if (reset_pin_n)              seen_low <= '0;
      else if (seen_low != KW'(MIN_PULSE)) seen_low <= seen_low + 1'b1;
   end

   AST_SHORT_PULSE_NO_ABORT: assert property (@(posedge clk) disable iff (!por_n)
      abort_req |-> (seen_low >= KW'(MIN_PULSE)));                        // R2
   AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
      abort_req |=> !abort_req);                                           // R3
   AST_READ_ARRAY_WITH_ABORT: assert property (@(posedge clk) disable iff (!por_n)
      read_array_req |-> abort_req);                                       // R3
   AST_NO_ACCESS_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
      !reset_pin_n |-> !accept_cmds);                                      // R4
   AST_READY_AT_ABORT: assert property (@(posedge clk) disable iff (!por_n)
      abort_req |-> !ryby_pull_low);                                       // R5
   AST_PULL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!por_n)
      ryby_pull_low |-> engine_busy);                                      // R9
endmodule

bind flash_rst_ready_seq flash_rst_ready_seq_chk #(.MIN_PULSE(MIN_PULSE)) u_chk (
   .clk            (clk),
   .por_n          (por_n),
   .reset_pin_n    (reset_pin_n),
   .engine_busy    (engine_busy),
   .abort_req      (abort_req),
   .read_array_req (read_array_req),
   .ryby_pull_low  (ryby_pull_low),
   .accept_cmds    (accept_cmds)
);

// File: tb/flash_rst_ready_seq_bench.sv
module flash_rst_ready_seq_bench;
   localparam int MIN_PULSE = 4;
   localparam int T_READY   = 20;
   localparam int T_RP      = 8;
   localparam int T_RH      = 5;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic reset_pin_n = 1'b1;
   logic engine_busy = 1'b0;
   logic abort_req, read_array_req, ryby_pull_low, accept_cmds;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   flash_rst_ready_seq #(
      .MIN_PULSE(MIN_PULSE), .T_READY(T_READY), .T_RP(T_RP), .T_RH(T_RH)
   ) u_flash_rst_ready_seq (
      .clk(clk), .por_n(por_n), .reset_pin_n(reset_pin_n), .engine_busy(engine_busy),
      .abort_req(abort_req), .read_array_req(read_array_req),
      .ryby_pull_low(ryby_pull_low), .accept_cmds(accept_cmds)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_por();
      check("R1", "accept after power-on", accept_cmds, 1);
      check("R1", "abort after power-on", abort_req, 0);
      check("R1", "read_array after power-on", read_array_req, 0);
      check("R1", "pull_low idle", ryby_pull_low, 0);
      engine_busy = 1'b1;
      tick(1);
      check("R9", "pull_low follows busy", ryby_pull_low, 1);
      engine_busy = 1'b0;
      tick(1);
      check("R9", "pull_low released with busy", ryby_pull_low, 0);
   endtask

   task automatic t_short();
      engine_busy = 1'b1;
      reset_pin_n = 1'b0;
      #0;
      check("R4", "accept while pin low", accept_cmds, 0);
      for (int k = 1; k < MIN_PULSE; k++) begin
         tick(1);
         check("R2", "no abort on short pulse", abort_req, 0);
         check("R2", "pull_low kept on short pulse", ryby_pull_low, 1);
         check("R4", "accept while pin low", accept_cmds, 0);
      end
      reset_pin_n = 1'b1;
      #0;
      check("R2", "accept back after short pulse", accept_cmds, 1);
      tick(3);
      check("R2", "no late abort", abort_req, 0);
      check("R2", "accept stays after short pulse", accept_cmds, 1);
      engine_busy = 1'b0;
      tick(1);
   endtask

   // hold the pin low for low_edges samples, then release and time the recovery
   task automatic t_full(input int low_edges, input bit busy, input string req);
      int tx, d;
      tx = busy ? T_READY : T_RP;
      d  = MIN_PULSE + tx - (low_edges + 1);
      if (d < T_RH) d = T_RH;
      engine_busy = busy;
      reset_pin_n = 1'b0;
      for (int k = 1; k <= low_edges; k++) begin
         tick(1);
         check("R4", "accept while pin low", accept_cmds, 0);
         if (k == MIN_PULSE) begin
            check("R3", "abort on qualifying sample", abort_req, 1);
            check("R3", "read_array on qualifying sample", read_array_req, 1);
            check("R5", "ready released at abort", ryby_pull_low, 0);
            engine_busy = 1'b0;
         end else begin
            check("R3", "abort only once", abort_req, 0);
         end
      end
      reset_pin_n = 1'b1;
      for (int j = 0; j <= d; j++) begin
         tick(1);
         check(req, $sformatf("accept %0d edges after release", j), accept_cmds, (j >= d) ? 1 : 0);
         check("R5", "ready stays released", ryby_pull_low, 0);
      end
      tick(2);
      check("R3", "no abort after recovery", abort_req, 0);
      check(req, "accept stays high", accept_cmds, 1);
   endtask

   task automatic t_glitch();
      engine_busy = 1'b0;
      reset_pin_n = 1'b0;
      tick(10);
      reset_pin_n = 1'b1;
      tick(2);
      check("R8", "no access early in settling", accept_cmds, 0);
      reset_pin_n = 1'b0;
      tick(2);
      check("R8", "short glitch in recovery no abort", abort_req, 0);
      reset_pin_n = 1'b1;
      for (int j = 0; j <= T_RH; j++) begin
         tick(1);
         check("R8", $sformatf("accept %0d edges after second release", j), accept_cmds,
               (j >= T_RH) ? 1 : 0);
         check("R8", "no abort from glitch", abort_req, 0);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      tick(2);
      por_n = 1'b1;
      tick(2);
      t_por();
      t_short();
      t_full(MIN_PULSE, 1'b1, "R6");
      t_full(30, 1'b1, "R6");
      t_full(MIN_PULSE + T_READY - T_RH - 1, 1'b1, "R6");
      t_full(MIN_PULSE, 1'b0, "R7");
      t_full(20, 1'b0, "R7");
      t_glitch();
      done = 1'b1;
      finish_run();
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end actual=0 expected=1");
         finish_run();
      end
   end
endmodule